// File: doc/BRIEF.md
# Programmable Clock Output Pin

This block puts a selectable, divided clock onto a device pin that it shares with an ordinary port bit and with a timer output. A small control register holds a two-bit frequency select and an enable bit. The selectable sources are the CPU clock Φ and three fixed fractions of the main clock fX: fX/8, fX/16 and fX/64. With a 4.19 MHz main clock these come to 524, 262 and 65.5 kHz. All sources are treated as levels in the main clock domain. The pin value is built from registers.

A change to the enable or to the frequency never reaches the pin in the middle of a pulse. Turning the output on waits for the newly selected source to be low. Turning it off waits for the active source to be low. Moving between frequencies while running waits until the old source and the new source are both low. As a result every high pulse on the pin is a full half period of one source. The clock reaches the pin only when three conditions hold: the port direction bit selects output, the port latch is 0, and the timer alternative is not chosen.

Top module: `pcl_clkout`

## Requirements
- R1: During and right after a synchronous reset the control readback is 4'b0000, the pin value is 0 and the pin drive enable is 0.
- R2: Select value 0 gives Φ, 1 gives fX/8, 2 gives fX/16 and 3 gives fX/64. Each is passed to the pin with its high time unchanged: Φ's own high time, then 4, 8 and 32 main-clock cycles.
- R3: A register write takes bit 3 as the enable and bits 1:0 as the select. The readback one cycle later is {enable, 0, select}. Bit 2 is ignored on write and reads 0.
- R4: The enable takes effect only while the relevant source is low, so enabling and disabling never leave a high pulse shorter than a full half period.
- R5: A select change while running takes effect only when both the old and the new source are low. Every high pulse on the pin has the full high time of one source.
- R6: With the output disabled, the port in output mode, latch 0 and the timer path off, the pin stays 0.
- R7: With the port in output mode, latch 1 and the timer path off, the pin is 1 one cycle later, whatever the clock state.
- R8: The pin drive enable follows the port direction bit (1 = output) with one cycle of latency.
- R9: With the timer path selected, the pin follows the timer input with one cycle of latency.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Main clock fX |
| rst | input | 1 | Synchronous active-high reset |
| phi_i | input | 1 | CPU clock Φ as a level synchronous to clk |
| wr_en | input | 1 | Control register write strobe |
| wr_data | input | 4 | Write data: bit 3 enable, bits 1:0 select |
| ctrl_rd | output | 4 | Control register readback |
| port_latch | input | 1 | Port output latch bit for this pin |
| port_out_mode | input | 1 | Port direction bit, 1 = output |
| tmr_sel | input | 1 | Selects the timer output for the pin |
| tmr_in | input | 1 | Timer channel output |
| pin_o | output | 1 | Registered pin value |
| pin_oe | output | 1 | Registered pin drive enable |

## Verification
The assertions assume that Φ arrives as a clean level sampled in the main clock domain. They also assume the port controls are steady for at least one cycle before their effect is checked. The timing properties are relative to the internal source vector, not to exact pulse counts. The stimulus drives every input on the falling clock edge. It generates Φ with a fixed high and low time of two cycles. It turns off pulse-width monitoring whenever it drives the latch, the direction bit or the timer path, because those may legitimately reshape the pin.

// File: rtl/pcl_pkg.sv
package pcl_pkg;
  localparam int CTRL_W  = 4;
  localparam int EN_BIT  = 3;
  localparam int RSV_BIT = 2;
  localparam int NSRC    = 4;

  typedef enum logic [1:0] {
    SRC_PHI   = 2'd0,
    SRC_DIV_A = 2'd1,
    SRC_DIV_B = 2'd2,
    SRC_DIV_C = 2'd3
  } src_sel_e;

  function automatic logic [CTRL_W-1:0] pack_rd(input logic en, input src_sel_e sel);
    logic [CTRL_W-1:0] v;
    v          = '0;
    v[EN_BIT]  = en;
    v[1:0]     = sel;
    return v;
  endfunction
endpackage

// File: rtl/pcl_divider.sv
module pcl_divider #(
  parameter int TAP_A = 3,
  parameter int TAP_B = 4,
  parameter int TAP_C = 6
) (
  input  logic       clk,
  input  logic       rst,
  output logic [2:0] taps
);
  localparam int CNT_W = TAP_C;
  localparam int TAPS [3] = '{TAP_A, TAP_B, TAP_C};

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) cnt <= '0;
    else     cnt <= cnt + 1'b1;
  end

  for (genvar g = 0; g < 3; g++) begin : g_tap
    assign taps[g] = cnt[TAPS[g]-1];
  end
endmodule

// File: rtl/pcl_ctrl_reg.sv
module pcl_ctrl_reg
  import pcl_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [CTRL_W-1:0] wr_data,
  output logic              req_en,
  output src_sel_e          req_sel,
  output logic [CTRL_W-1:0] ctrl_rd
);
  always_ff @(posedge clk) begin
    if (rst) begin
      req_en  <= 1'b0;
      req_sel <= SRC_PHI;
    end else if (wr_en) begin
      req_en  <= wr_data[EN_BIT];
      req_sel <= src_sel_e'(wr_data[1:0]);
    end
  end

  assign ctrl_rd = pack_rd(req_en, req_sel);
endmodule

// File: rtl/pcl_switch.sv
module pcl_switch
  import pcl_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic [NSRC-1:0] src_vec,
  input  logic            req_en,
  input  src_sel_e        req_sel,
  output logic            act_en,
  output src_sel_e        act_sel,
  output logic            gated
);
  logic cur_lvl, nxt_lvl;

  assign cur_lvl = src_vec[act_sel];
  assign nxt_lvl = src_vec[req_sel];

  always_ff @(posedge clk) begin
    if (rst) begin
      act_en  <= 1'b0;
      act_sel <= SRC_PHI;
      gated   <= 1'b0;
    end else begin
      gated <= act_en & cur_lvl;
      if (!act_en) begin
        if (req_en && !nxt_lvl) begin
          act_en  <= 1'b1;
          act_sel <= req_sel;
        end
      end else if (!req_en) begin
        if (!cur_lvl) act_en <= 1'b0;
      end else if (req_sel != act_sel && !cur_lvl && !nxt_lvl) begin
        act_sel <= req_sel;
      end
    end
  end
endmodule

// File: rtl/pcl_pin_mux.sv
module pcl_pin_mux (
  input  logic clk,
  input  logic rst,
  input  logic gated,
  input  logic port_latch,
  input  logic port_out_mode,
  input  logic tmr_sel,
  input  logic tmr_in,
  output logic pin_o,
  output logic pin_oe
);
  always_ff @(posedge clk) begin
    if (rst) begin
      pin_o  <= 1'b0;
      pin_oe <= 1'b0;
    end else begin
      pin_o  <= tmr_sel ? tmr_in : (port_latch | gated);
      pin_oe <= port_out_mode;
    end
  end
endmodule

// File: rtl/pcl_clkout.sv
module pcl_clkout
  import pcl_pkg::*;
#(
  parameter int TAP_A = 3,
  parameter int TAP_B = 4,
  parameter int TAP_C = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              phi_i,
  input  logic              wr_en,
  input  logic [CTRL_W-1:0] wr_data,
  output logic [CTRL_W-1:0] ctrl_rd,
  input  logic              port_latch,
  input  logic              port_out_mode,
  input  logic              tmr_sel,
  input  logic              tmr_in,
  output logic              pin_o,
  output logic              pin_oe
);
  logic            phi_q;
  logic [2:0]      taps;
  logic [NSRC-1:0] src_vec;
  logic            req_en, act_en, gated;
  src_sel_e        req_sel, act_sel;

  always_ff @(posedge clk) begin
    if (rst) phi_q <= 1'b0;
    else     phi_q <= phi_i;
  end

  pcl_divider #(.TAP_A(TAP_A), .TAP_B(TAP_B), .TAP_C(TAP_C)) u_div (
    .clk(clk), .rst(rst), .taps(taps)
  );

  assign src_vec = {taps, phi_q};

  pcl_ctrl_reg u_reg (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
    .req_en(req_en), .req_sel(req_sel), .ctrl_rd(ctrl_rd)
  );

  pcl_switch u_sw (
    .clk(clk), .rst(rst), .src_vec(src_vec), .req_en(req_en), .req_sel(req_sel),
    .act_en(act_en), .act_sel(act_sel), .gated(gated)
  );

  pcl_pin_mux u_pin (
    .clk(clk), .rst(rst), .gated(gated), .port_latch(port_latch),
    .port_out_mode(port_out_mode), .tmr_sel(tmr_sel), .tmr_in(tmr_in),
    .pin_o(pin_o), .pin_oe(pin_oe)
  );
endmodule

// File: rtl/pcl_clkout_chk.sv
module pcl_clkout_chk (
  input logic       clk,
  input logic       rst,
  input logic       wr_en,
  input logic [3:0] wr_data,
  input logic [3:0] ctrl_rd,
  input logic       act_en,
  input logic [1:0] act_sel,
  input logic [3:0] src_vec,
  input logic       port_latch,
  input logic       port_out_mode,
  input logic       tmr_sel,
  input logic       pin_o,
  input logic       pin_oe
);
  p_reset_state_r1: assert property (@(posedge clk)
    rst |=> (ctrl_rd == 4'b0000 && !pin_o && !pin_oe));

  p_readback_r3: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> ctrl_rd == {$past(wr_data[3]), 1'b0, $past(wr_data[1:0])});

  p_enable_low_r4: assert property (@(posedge clk) disable iff (rst)
    (act_en && !$past(act_en)) |-> (($past(src_vec) & (4'b0001 << act_sel)) == 4'b0000));

  p_disable_low_r4: assert property (@(posedge clk) disable iff (rst)
    (!act_en && $past(act_en)) |-> (($past(src_vec) & (4'b0001 << act_sel)) == 4'b0000));

  p_switch_low_r5: assert property (@(posedge clk) disable iff (rst)
    (act_en && $past(act_en) && act_sel != $past(act_sel)) |->
      (($past(src_vec) & ((4'b0001 << act_sel) | (4'b0001 << $past(act_sel)))) == 4'b0000));

  p_latch_high_r7: assert property (@(posedge clk) disable iff (rst)
    $past(port_out_mode && port_latch && !tmr_sel) |-> pin_o);

  p_drive_follow_r8: assert property (@(posedge clk) disable iff (rst)
    pin_oe == $past(port_out_mode));
endmodule

bind pcl_clkout pcl_clkout_chk u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .ctrl_rd(ctrl_rd),
  .act_en(act_en), .act_sel(act_sel), .src_vec(src_vec),
  .port_latch(port_latch), .port_out_mode(port_out_mode), .tmr_sel(tmr_sel),
  .pin_o(pin_o), .pin_oe(pin_oe)
);

// File: tb/test_pcl_clkout.sv
module test_pcl_clkout;
  logic       clk = 0, rst = 1, phi_i = 0, wr_en = 0;
  logic [3:0] wr_data = 0;
  logic [3:0] ctrl_rd;
  logic       port_latch = 0, port_out_mode = 0, tmr_sel = 0, tmr_in = 0;
  logic       pin_o, pin_oe;

  int total = 0, bad = 0;
  bit done = 0, watch = 0;
  int    exp_q[$];
  string tag_q[$];

  always #2 clk = ~clk;

  pcl_clkout i_pcl_clkout (
    .clk(clk), .rst(rst), .phi_i(phi_i), .wr_en(wr_en), .wr_data(wr_data),
    .ctrl_rd(ctrl_rd), .port_latch(port_latch), .port_out_mode(port_out_mode),
    .tmr_sel(tmr_sel), .tmr_in(tmr_in), .pin_o(pin_o), .pin_oe(pin_oe)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Phi: two cycles high, two low, driven on falling edges
  initial forever begin
    repeat (2) @(negedge clk);
    phi_i = ~phi_i;
  end

  // Monitor: measures each fully observed high pulse
  initial begin
    int run = 0;
    bit prev = 0, valid = 0;
    forever begin
      @(negedge clk);
      if (!watch) begin
        valid = 0; run = 0; prev = pin_o;
      end else begin
        if (pin_o) begin
          if (!prev) begin run = 1; valid = 1; end
          else run++;
        end else if (prev && valid) begin
          chk(run == 2 || run == 4 || run == 8 || run == 32, "R4/R5 full pulse", run, 0);
          if (exp_q.size() > 0) begin
            int e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            chk(run == e, t, run, e);
          end
        end
        prev = pin_o;
      end
    end
  end

  task automatic wr(input logic [3:0] d);
    @(negedge clk);
    wr_en = 1; wr_data = d;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic expect_width(input int w, input string tag);
    bit p;
    repeat (80) @(negedge clk);
    p = pin_o;
    forever begin
      @(negedge clk);
      if (p && !pin_o) break;
      p = pin_o;
    end
    for (int i = 0; i < 3; i++) begin
      exp_q.push_back(w);
      tag_q.push_back(tag);
    end
    wait (exp_q.size() == 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (5) @(negedge clk);
    chk(ctrl_rd == 4'b0000, "R1 readback", ctrl_rd, 0);
    chk(pin_o == 0, "R1 pin", pin_o, 0);
    chk(pin_oe == 0, "R1 drive", pin_oe, 0);
    rst = 0;
    port_out_mode = 1;
    @(negedge clk);
    chk(pin_oe == 1, "R8 drive on", pin_oe, 1);
    watch = 1;

    wr(4'b1000);
    chk(ctrl_rd == 4'b1000, "R3 readback", ctrl_rd, 8);
    expect_width(2, "R2 sel0 phi");
    wr(4'b1001);
    expect_width(4, "R2 sel1 fx/8");
    wr(4'b1010);
    expect_width(8, "R2 sel2 fx/16");
    wr(4'b1011);
    chk(ctrl_rd == 4'b1011, "R3 readback", ctrl_rd, 11);
    expect_width(32, "R2 sel3 fx/64");

    wr(4'b1100);
    chk(ctrl_rd == 4'b1000, "R3 bit2 ignored", ctrl_rd, 8);
    expect_width(2, "R3 bit2 no effect");

    wr(4'b0000);
    repeat (100) @(negedge clk);
    chk(ctrl_rd == 4'b0000, "R3 disable readback", ctrl_rd, 0);
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      chk(pin_o == 0, "R6 disabled low", pin_o, 0);
    end

    // Rapid enable/disable and select changes at varying offsets
    for (int i = 0; i < 24; i++) begin
      wr(4'b1000 | (i % 4));
      repeat (i % 7) @(negedge clk);
      wr((i % 3 == 0) ? 4'b0000 : (4'b1000 | ((i + 1) % 4)));
      repeat (i) @(negedge clk);
    end
    wr(4'b0000);
    repeat (100) @(negedge clk);
    watch = 0;

    wr(4'b1001);
    @(negedge clk);
    port_latch = 1;
    repeat (2) @(negedge clk);
    for (int i = 0; i < 12; i++) begin
      @(negedge clk);
      chk(pin_o == 1, "R7 latch high", pin_o, 1);
    end
    port_latch = 0;

    port_out_mode = 0;
    repeat (2) @(negedge clk);
    chk(pin_oe == 0, "R8 drive off", pin_oe, 0);
    port_out_mode = 1;

    tmr_sel = 1;
    for (int i = 0; i < 6; i++) begin
      tmr_in = i[0];
      @(negedge clk);
      chk(pin_o == tmr_in, "R9 timer path", pin_o, tmr_in);
    end
    tmr_sel = 0;

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule